// File: doc/BRIEF.md
# Vector Register Layout Tracker

This block keeps a record of the byte layout of each register in a 32-entry vector register file. The layout is written as a 2-bit element-width code: 0 means 8-bit elements, 1 means 16-bit, 2 means 32-bit and 3 means 64-bit. Each incoming vector instruction names up to three operand registers: the first source (vs1), the second source (vs2) and the destination (vd). For each one the instruction gives the element width it needs and a flag that says whether the old contents are read. If a read operand's stored layout differs from the width it needs, the block issues a layout-conversion micro-operation for that register before it lets the instruction through. A slide engine outside the block carries out that micro-operation.

The instruction, the micro-operation and the issued instruction each travel on a valid/ready stream. The input stream is accepted only while the block is idle, so one instruction at a time is in flight. A micro-operation stays offered, unchanged, until the consumer takes it. The block then waits for a separate completion pulse before it offers the next one. The issued instruction is also held stable until it is taken. After that, a commit pulse with an ok flag says whether the dispatch went through. Only a successful commit of an instruction that writes its destination records the new layout of that destination.

Top module: `vreg_layout_tracker`

## Requirements
- R1: After reset every register's layout code is 0 (8-bit), in_ready is 1, and uop_valid and out_valid are 0.
- R2: in_ready is 1 only while the block is idle. After an accepted instruction it stays 0 until the commit pulse that ends that instruction.
- R3: An operand slot requests a conversion only when its read flag is set (in_rd bit 0 = vs1, bit 1 = vs2, bit 2 = vd) and its required code differs from the stored code of its register. A slot with its read flag clear never requests one.
- R4: Conversions are served one at a time in slot order vs2, vs1, vd. A slot is dropped when an earlier read slot in that order names the same register, so each register gets at most one conversion per instruction.
- R5: A micro-operation carries the register index, the stored (old) code and the required (new) code. When uop_done arrives after the micro-operation was taken, the register's stored code becomes the new code.
- R6: The next micro-operation, or the issued instruction, is offered only after uop_done for the one in flight. A uop_done pulse at any other time is ignored.
- R7: Once the last conversion completes (or at once, the cycle after acceptance, if none is needed), the original instruction is offered on the output with all its fields unchanged.
- R8: When uop_valid or out_valid is 1 and the matching ready is 0, the valid stays 1 and the payload stays stable on the next cycle.
- R9: After the output handshake, a commit pulse returns the block to idle. If commit_ok is 1 and out_wr was 1, the destination's stored code becomes out_ew_vd; otherwise no code changes. A commit pulse at any other time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle and taking an instruction |
| in_vs1 | input | 5 | First source register index |
| in_vs2 | input | 5 | Second source register index |
| in_vd | input | 5 | Destination register index |
| in_rd | input | 3 | Read flags: bit 0 vs1, bit 1 vs2, bit 2 vd |
| in_wr | input | 1 | Instruction writes vd |
| in_ew_vs1 | input | 2 | Width code required for vs1 |
| in_ew_vs2 | input | 2 | Width code required for vs2 |
| in_ew_vd | input | 2 | Width code required for vd |
| uop_valid | output | 1 | Conversion micro-operation offered |
| uop_ready | input | 1 | Slide engine takes the micro-operation |
| uop_reg | output | 5 | Register to convert |
| uop_old_ew | output | 2 | Current layout code of that register |
| uop_new_ew | output | 2 | Target layout code |
| uop_done | input | 1 | Pulse: micro-operation finished |
| out_valid | output | 1 | Instruction issued |
| out_ready | input | 1 | Downstream takes the instruction |
| out_vs1 | output | 5 | Issued vs1 index |
| out_vs2 | output | 5 | Issued vs2 index |
| out_vd | output | 5 | Issued vd index |
| out_rd | output | 3 | Issued read flags |
| out_wr | output | 1 | Issued write flag |
| out_ew_vs1 | output | 2 | Issued vs1 width code |
| out_ew_vs2 | output | 2 | Issued vs2 width code |
| out_ew_vd | output | 2 | Issued vd width code |
| commit | input | 1 | Pulse: dispatch outcome known |
| commit_ok | input | 1 | Dispatch succeeded, record vd layout |

## Verification
The only place a stored layout code shows is the uop_old_ew field of a later conversion, or the absence of a conversion that should have been needed. A wrong tag therefore stays hidden until an instruction reads that register, and then shows in the same transaction as a wrong count of micro-operations or a wrong old code. The bench reads tags back this way right after each commit and each completed conversion, so a write that is lost or wrongly taken shows up within the next instruction. Errors in ordering or de-duplication show up at once in the sequence of uop_reg values for a single instruction.

// File: rtl/vlt_pkg.sv
package vlt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_ISSUE,
    ST_COMMIT
  } vlt_state_e;

  localparam int NUM_SLOTS = 3;
  localparam logic [1:0] SLOT_VS1 = 2'd0;
  localparam logic [1:0] SLOT_VS2 = 2'd1;
  localparam logic [1:0] SLOT_VD  = 2'd2;

endpackage

// File: rtl/vlt_tag_file.sv
module vlt_tag_file #(
  parameter int NUM_REGS = 32,
  parameter int EW_W     = 2,
  parameter int NRD      = 4,
  parameter logic [EW_W-1:0] RESET_EW = '0,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IDX_W-1:0]          waddr,
  input  logic [EW_W-1:0]           wdata,
  input  logic [NRD-1:0][IDX_W-1:0] raddr,
  output logic [NRD-1:0][EW_W-1:0]  rdata
);

  logic [NUM_REGS-1:0][EW_W-1:0] tags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) tags_q[i] <= RESET_EW;
    end else if (we) begin
      tags_q[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = tags_q[raddr[p]];
  end

endmodule

// File: rtl/vlt_req_gen.sv
module vlt_req_gen
  import vlt_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int EW_W  = 2
) (
  input  logic [NUM_SLOTS-1:0][IDX_W-1:0] idx,
  input  logic [NUM_SLOTS-1:0][EW_W-1:0]  need,
  input  logic [NUM_SLOTS-1:0][EW_W-1:0]  tag,
  input  logic [NUM_SLOTS-1:0]            rd,
  output logic [NUM_SLOTS-1:0]            req
);

  logic [NUM_SLOTS-1:0] raw;
  logic                 dup_vs1;
  logic                 dup_vd;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_raw
    assign raw[s] = rd[s] && (need[s] != tag[s]);
  end

  // Service order is vs2, vs1, vd: a later slot that repeats the register
  // of an earlier read slot is dropped.
  assign dup_vs1 = rd[SLOT_VS2] && (idx[SLOT_VS1] == idx[SLOT_VS2]);
  assign dup_vd  = (rd[SLOT_VS2] && (idx[SLOT_VD] == idx[SLOT_VS2])) ||
                   (rd[SLOT_VS1] && (idx[SLOT_VD] == idx[SLOT_VS1]));

  assign req[SLOT_VS2] = raw[SLOT_VS2];
  assign req[SLOT_VS1] = raw[SLOT_VS1] && !dup_vs1;
  assign req[SLOT_VD]  = raw[SLOT_VD]  && !dup_vd;

endmodule

// File: rtl/vlt_pick.sv
module vlt_pick
  import vlt_pkg::*;
(
  input  logic [NUM_SLOTS-1:0] req,
  output logic                 any,
  output logic [1:0]           slot
);

  assign any = |req;

  always_comb begin
    if (req[SLOT_VS2])      slot = SLOT_VS2;
    else if (req[SLOT_VS1]) slot = SLOT_VS1;
    else                    slot = SLOT_VD;
  end

endmodule

// File: rtl/vreg_layout_tracker.sv
module vreg_layout_tracker
  import vlt_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int EW_W     = 2,
  parameter logic [EW_W-1:0] RESET_EW = '0,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_vs1,
  input  logic [IDX_W-1:0] in_vs2,
  input  logic [IDX_W-1:0] in_vd,
  input  logic [2:0]       in_rd,
  input  logic             in_wr,
  input  logic [EW_W-1:0]  in_ew_vs1,
  input  logic [EW_W-1:0]  in_ew_vs2,
  input  logic [EW_W-1:0]  in_ew_vd,
  output logic             uop_valid,
  input  logic             uop_ready,
  output logic [IDX_W-1:0] uop_reg,
  output logic [EW_W-1:0]  uop_old_ew,
  output logic [EW_W-1:0]  uop_new_ew,
  input  logic             uop_done,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] out_vs1,
  output logic [IDX_W-1:0] out_vs2,
  output logic [IDX_W-1:0] out_vd,
  output logic [2:0]       out_rd,
  output logic             out_wr,
  output logic [EW_W-1:0]  out_ew_vs1,
  output logic [EW_W-1:0]  out_ew_vs2,
  output logic [EW_W-1:0]  out_ew_vd,
  input  logic             commit,
  input  logic             commit_ok
);

  localparam int NRD = NUM_SLOTS + 1;

  vlt_state_e state_q, state_d;

  logic [NUM_SLOTS-1:0][IDX_W-1:0] in_idx, ins_idx_q;
  logic [NUM_SLOTS-1:0][EW_W-1:0]  in_ew, ins_ew_q;
  logic [NUM_SLOTS-1:0]            ins_rd_q;
  logic                            ins_wr_q;

  logic [NUM_SLOTS-1:0] req_new, req_q;
  logic                 pick_any;
  logic [1:0]           pick_slot;

  // Buffers for the conversion in flight.
  logic [IDX_W-1:0] buf_reg_q;
  logic [EW_W-1:0]  buf_new_q;

  logic [NRD-1:0][IDX_W-1:0] raddr;
  logic [NRD-1:0][EW_W-1:0]  rdata;
  logic                      tag_we;
  logic [IDX_W-1:0]          tag_waddr;
  logic [EW_W-1:0]           tag_wdata;

  logic accept, uop_fire, out_fire, done_ok, commit_ok_wr;

  assign in_idx = {in_vd, in_vs2, in_vs1};
  assign in_ew  = {in_ew_vd, in_ew_vs2, in_ew_vs1};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_raddr
    assign raddr[s] = in_idx[s];
  end
  assign raddr[NUM_SLOTS] = ins_idx_q[pick_slot];

  vlt_tag_file #(
    .NUM_REGS (NUM_REGS),
    .EW_W     (EW_W),
    .NRD      (NRD),
    .RESET_EW (RESET_EW)
  ) u_tags (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tag_we),
    .waddr (tag_waddr),
    .wdata (tag_wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  vlt_req_gen #(
    .IDX_W (IDX_W),
    .EW_W  (EW_W)
  ) u_req (
    .idx  (in_idx),
    .need (in_ew),
    .tag  (rdata[NUM_SLOTS-1:0]),
    .rd   (in_rd),
    .req  (req_new)
  );

  vlt_pick u_pick (
    .req  (req_q),
    .any  (pick_any),
    .slot (pick_slot)
  );

  assign in_ready  = (state_q == ST_IDLE);
  assign uop_valid = (state_q == ST_SEND);
  assign out_valid = (state_q == ST_ISSUE);

  assign accept       = in_valid && in_ready;
  assign uop_fire     = uop_valid && uop_ready;
  assign out_fire     = out_valid && out_ready;
  assign done_ok      = (state_q == ST_WAIT) && uop_done;
  assign commit_ok_wr = (state_q == ST_COMMIT) && commit && commit_ok && ins_wr_q;

  assign uop_reg    = ins_idx_q[pick_slot];
  assign uop_new_ew = ins_ew_q[pick_slot];
  assign uop_old_ew = rdata[NUM_SLOTS];

  assign tag_we    = done_ok || commit_ok_wr;
  assign tag_waddr = done_ok ? buf_reg_q : ins_idx_q[SLOT_VD];
  assign tag_wdata = done_ok ? buf_new_q : ins_ew_q[SLOT_VD];

  assign out_vs1    = ins_idx_q[SLOT_VS1];
  assign out_vs2    = ins_idx_q[SLOT_VS2];
  assign out_vd     = ins_idx_q[SLOT_VD];
  assign out_ew_vs1 = ins_ew_q[SLOT_VS1];
  assign out_ew_vs2 = ins_ew_q[SLOT_VS2];
  assign out_ew_vd  = ins_ew_q[SLOT_VD];
  assign out_rd     = ins_rd_q;
  assign out_wr     = ins_wr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept)   state_d = (|req_new) ? ST_SEND : ST_ISSUE;
      ST_SEND:   if (uop_fire) state_d = ST_WAIT;
      ST_WAIT:   if (uop_done) state_d = pick_any ? ST_SEND : ST_ISSUE;
      ST_ISSUE:  if (out_fire) state_d = ST_COMMIT;
      ST_COMMIT: if (commit)   state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ins_idx_q <= '0;
      ins_ew_q  <= '0;
      ins_rd_q  <= '0;
      ins_wr_q  <= 1'b0;
      req_q     <= '0;
      buf_reg_q <= '0;
      buf_new_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        ins_idx_q <= in_idx;
        ins_ew_q  <= in_ew;
        ins_rd_q  <= in_rd;
        ins_wr_q  <= in_wr;
        req_q     <= req_new;
      end
      if (uop_fire) begin
        buf_reg_q        <= uop_reg;
        buf_new_q        <= uop_new_ew;
        req_q[pick_slot] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vlt_checker.sv
module vlt_checker #(
  parameter int IDX_W = 5,
  parameter int EW_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             uop_valid,
  input logic             uop_ready,
  input logic [IDX_W-1:0] uop_reg,
  input logic [EW_W-1:0]  uop_old_ew,
  input logic [EW_W-1:0]  uop_new_ew,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] out_vd,
  input logic [EW_W-1:0]  out_ew_vd
);

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  a_r2_idle_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !uop_valid && !out_valid);

  a_r6_single_stream: assert property (@(posedge clk) disable iff (!rst_n)
    !(uop_valid && out_valid));

  a_r6_wait_for_done: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_ready |=> !uop_valid && !out_valid);

  a_r3_real_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> uop_old_ew != uop_new_ew);

  a_r8_uop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_reg) &&
      $stable(uop_old_ew) && $stable(uop_new_ew));

  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vd) && $stable(out_ew_vd));

endmodule

bind vreg_layout_tracker vlt_checker #(
  .IDX_W (IDX_W),
  .EW_W  (EW_W)
) u_vlt_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .uop_valid  (uop_valid),
  .uop_ready  (uop_ready),
  .uop_reg    (uop_reg),
  .uop_old_ew (uop_old_ew),
  .uop_new_ew (uop_new_ew),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_vd     (out_vd),
  .out_ew_vd  (out_ew_vd)
);

// File: tb/tb_vreg_layout_tracker.sv
module tb_vreg_layout_tracker;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       in_valid = 0, in_wr = 0, uop_ready = 0, uop_done = 0;
  logic       out_ready = 0, commit = 0, commit_ok = 0;
  logic [4:0] in_vs1 = 0, in_vs2 = 0, in_vd = 0;
  logic [2:0] in_rd = 0;
  logic [1:0] in_ew_vs1 = 0, in_ew_vs2 = 0, in_ew_vd = 0;
  logic       in_ready, uop_valid, out_valid, out_wr;
  logic [4:0] uop_reg, out_vs1, out_vs2, out_vd;
  logic [1:0] uop_old_ew, uop_new_ew, out_ew_vs1, out_ew_vs2, out_ew_vd;
  logic [2:0] out_rd;

  vreg_layout_tracker dut (.*);

  int errors = 0;
  int checks = 0;
  int nu;
  int cap_reg[4], cap_old[4], cap_new[4];

  typedef struct packed {
    int vs1; int vs2; int vd; int rd; int wr; int e1; int e2; int ed; int ok;
    int n; int r0; int o0; int w0; int r1; int o1; int w1;
  } vec_t;

  // Width codes: 0=8b 1=16b 2=32b 3=64b. rd bits: 0 vs1, 1 vs2, 2 vd.
  localparam vec_t VECS [8] = '{
    '{1, 2, 3, 3, 1, 0, 0, 0, 1,  0, 0, 0, 0, 0, 0, 0},
    '{1, 2, 4, 3, 1, 1, 2, 1, 1,  2, 2, 0, 2, 1, 0, 1},
    '{2, 2, 5, 3, 1, 1, 1, 0, 1,  1, 2, 2, 1, 0, 0, 0},
    '{6, 7, 4, 7, 1, 3, 0, 2, 1,  2, 6, 0, 3, 4, 1, 2},
    '{9, 9, 9, 1, 0, 2, 3, 3, 1,  1, 9, 0, 2, 0, 0, 0},
    '{4, 4, 4, 7, 1, 0, 3, 1, 1,  1, 4, 2, 3, 0, 0, 0},
    '{31, 0, 4, 7, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0},
    '{31, 0, 0, 1, 0, 3, 0, 0, 1, 1, 31, 0, 3, 0, 0, 0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Offers one instruction, serves all conversions, checks the issued fields,
  // then commits with the given ok flag.
  task automatic run(input int vs1, input int vs2, input int vd, input int rd,
                     input int wr, input int e1, input int e2, input int ed, input int ok);
    @(negedge clk);
    in_valid = 1; in_vs1 = 5'(vs1); in_vs2 = 5'(vs2); in_vd = 5'(vd);
    in_rd = 3'(rd); in_wr = 1'(wr); in_ew_vs1 = 2'(e1); in_ew_vs2 = 2'(e2); in_ew_vd = 2'(ed);
    @(negedge clk);
    in_valid = 0;
    nu = 0;
    for (int k = 0; k < 40 && !out_valid; k++) begin
      if (uop_valid) begin
        if (nu < 4) begin
          cap_reg[nu] = int'(uop_reg); cap_old[nu] = int'(uop_old_ew); cap_new[nu] = int'(uop_new_ew);
        end
        nu++;
        uop_ready = 1;
        @(negedge clk);
        uop_ready = 0; uop_done = 1;
        @(negedge clk);
        uop_done = 0;
      end else begin
        @(negedge clk);
      end
    end
    chk("R7", "issued fields",
        int'({out_valid, out_vs1, out_vs2, out_vd, out_rd, out_wr, out_ew_vs1, out_ew_vs2, out_ew_vd}),
        int'({1'b1, 5'(vs1), 5'(vs2), 5'(vd), 3'(rd), 1'(wr), 2'(e1), 2'(e2), 2'(ed)}));
    out_ready = 1;
    @(negedge clk);
    out_ready = 0; commit = 1; commit_ok = 1'(ok);
    @(negedge clk);
    commit = 0; commit_ok = 0;
    chk("R9", "in_ready after commit", int'(in_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "in_ready", int'(in_ready), 1);
    chk("R1", "uop_valid", int'(uop_valid), 0);
    chk("R1", "out_valid", int'(out_valid), 0);

    // Table walk: R3 mismatch, R4 order and de-duplication, R5 contents.
    foreach (VECS[i]) begin
      run(VECS[i].vs1, VECS[i].vs2, VECS[i].vd, VECS[i].rd, VECS[i].wr,
          VECS[i].e1, VECS[i].e2, VECS[i].ed, VECS[i].ok);
      chk("R3", $sformatf("vec%0d uop count", i), nu, VECS[i].n);
      if (VECS[i].n > 0) begin
        chk("R4", $sformatf("vec%0d first reg", i), cap_reg[0], VECS[i].r0);
        chk("R5", $sformatf("vec%0d first old", i), cap_old[0], VECS[i].o0);
        chk("R5", $sformatf("vec%0d first new", i), cap_new[0], VECS[i].w0);
      end
      if (VECS[i].n > 1) begin
        chk("R4", $sformatf("vec%0d second reg", i), cap_reg[1], VECS[i].r1);
        chk("R5", $sformatf("vec%0d second old", i), cap_old[1], VECS[i].o1);
        chk("R5", $sformatf("vec%0d second new", i), cap_new[1], VECS[i].w1);
      end
    end

    // R9: discarded commit leaves reg 12 at reset code, successful one records.
    run(0, 0, 12, 0, 1, 0, 0, 2, 0);
    chk("R9", "no conversion for write-only vd", nu, 0);
    run(12, 0, 0, 1, 0, 2, 0, 0, 1);
    chk("R9", "discarded commit count", nu, 1);
    chk("R9", "discarded commit old code", cap_old[0], 0);
    run(0, 0, 12, 0, 1, 0, 0, 3, 1);
    run(12, 0, 0, 1, 0, 3, 0, 0, 1);
    chk("R9", "committed vd code matches", nu, 0);
    run(12, 0, 0, 1, 0, 1, 0, 0, 1);
    chk("R9", "committed vd old code", cap_old[0], 3);

    // R8 / R6 / R2: back-pressure on both streams, stray pulses ignored.
    @(negedge clk);
    in_valid = 1; in_vs1 = 20; in_rd = 3'b001; in_ew_vs1 = 1; in_wr = 0;
    @(negedge clk);
    in_valid = 0;
    chk("R2", "in_ready while busy", int'(in_ready), 0);
    uop_done = 1;
    @(negedge clk);
    uop_done = 0;
    @(negedge clk);
    chk("R8", "uop held", int'(uop_valid), 1);
    chk("R6", "early done ignored, reg", int'(uop_reg), 20);
    uop_ready = 1;
    @(negedge clk);
    uop_ready = 0;
    repeat (2) @(negedge clk);
    chk("R6", "no issue before done", int'(out_valid), 0);
    uop_done = 1;
    @(negedge clk);
    uop_done = 0;
    commit = 1; commit_ok = 1;
    @(negedge clk);
    commit = 0; commit_ok = 0;
    @(negedge clk);
    chk("R8", "out held", int'(out_valid), 1);
    chk("R9", "early commit ignored", int'(in_ready), 0);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0; commit = 1;
    @(negedge clk);
    commit = 0;
    chk("R2", "idle after commit", int'(in_ready), 1);
    run(20, 0, 0, 1, 0, 1, 0, 0, 1);
    chk("R5", "tag set by completed conversion", nu, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule